// File: doc/BRIEF.md
# Segment Register Load Checker

This block carries out a request to place a 16-bit selector into one of six segment registers. It breaks the selector into a privilege request, a table choice and a descriptor index. It forms the byte address of the 8-byte descriptor in the global or the local table and reads the descriptor as two 32-bit words over a valid/ready memory port. It then compares privileges and either fills the register's hidden cache or raises a general-protection fault.

Because the privilege test runs only while the register is being loaded, later address generation reads base, limit and attributes straight from the cache through a combinational query port and never touches the tables again. The code register (index 0) cannot be loaded through the request port. Only a separate far-transfer input may rewrite its selector, and the current privilege level comes from that selector's two low bits.

Top module: `segLoadUnit`

## Requirements
- R1: After reset every cache entry holds selector 0, base 0, limit 0xFFFFFFFF, DPL 0, attributes 0 and valid 1, and `busy` is 0.
- R2: The first descriptor read goes to `ldtBase` when selector bit 2 is 1, or to `gdtBase` when it is 0, plus selector bits [15:3] times 8. The second read goes to that address plus 4, and it is issued only after the first response.
- R3: A committed entry takes base = {hi[31:24], hi[7:0], lo[31:16]}, DPL = hi[14:13] and attributes = {hi[23:20], hi[15:8]}, where lo and hi are the first and second words read.
- R4: The 20-bit limit is {hi[19:16], lo[15:0]}. When hi[23] is 1 the stored limit is that value shifted left by 12 with 0xFFF filled below. Otherwise it is zero-extended.
- R5: The load faults when max(CPL, RPL) > DPL, with RPL being selector bits [1:0]. Otherwise it commits. On a fault the target entry keeps all of its previous contents.
- R6: CPL is bits [1:0] of the selector held in entry 0. A pulse on `csFarValid` replaces that selector with `csFarSel` and leaves entry 0's other fields unchanged.
- R7: A request that targets entry 0 (`reqSeg` = 0) faults without any memory read and leaves entry 0 unchanged.
- R8: A null selector (bits [15:2] all zero) aimed at entry 1, 3, 4 or 5 completes without a read and without a fault. It stores the selector, clears valid, and keeps base, limit, DPL and attributes.
- R9: A null selector aimed at entry 2 (the stack register) faults without a read and leaves the entry unchanged.
- R10: A fault drives `faultPulse` high for exactly one cycle, with `faultSel` equal to the offending selector.
- R11: While `busy` is 1, a request is ignored. It causes no read and no change to any entry.
- R12: A successful load stores the selector, sets valid to 1 and leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Load request, accepted when `busy` is 0 |
| reqSeg | input | 3 | Target register: 0 code, 1 data, 2 stack, 3 to 5 extra |
| reqSel | input | 16 | Selector to load |
| busy | output | 1 | A load is in progress |
| gdtBase | input | 32 | Global table base address |
| ldtBase | input | 32 | Local table base address |
| memReqValid | output | 1 | Descriptor read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Byte address of the word read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data |
| csFarValid | input | 1 | Far-transfer write of the code selector |
| csFarSel | input | 16 | New code selector |
| qrySeg | input | 3 | Entry to observe |
| qrySel | output | 16 | Cached selector |
| qryBase | output | 32 | Cached base |
| qryLimit | output | 32 | Cached byte limit |
| qryDpl | output | 2 | Cached descriptor privilege |
| qryAttr | output | 12 | Cached attribute bits |
| qryValid | output | 1 | Entry holds a usable descriptor |
| faultPulse | output | 1 | General-protection fault, one cycle |
| faultSel | output | 16 | Selector that faulted |

## Verification
The privilege comparison is driven with CPL, RPL and DPL combinations. In some of them CPL alone decides the outcome, in some RPL alone decides it, and in one the maximum of the two exactly equals DPL, which separates a correct maximum from a plain comparison of either input. Address formation is exercised from both tables, with a small index and with the largest index, so a wrong table choice, a wrong scale or a dropped top bit each shows up as a different address. Descriptors with the granularity bit set and clear tell limit expansion apart from zero extension. Null selectors, stack targets, code targets and requests made while busy each check that the block takes the path with no read and that the cache keeps its state.

// File: rtl/segLoadPkg.sv
package segLoadPkg;
  localparam int SEL_W     = 16;
  localparam int ADDR_W    = 32;
  localparam int SEG_IDX_W = 3;
  localparam int ATTR_W    = 12;

  localparam logic [SEG_IDX_W-1:0] SEG_CODE  = 3'd0;
  localparam logic [SEG_IDX_W-1:0] SEG_STACK = 3'd2;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [1:0]        dpl;
    logic [ATTR_W-1:0] attr;
    logic              valid;
  } segCache_t;

  typedef struct packed {
    logic latchReq;
    logic latchLo;
    logic latchHi;
    logic addrHi;
    logic commit;
    logic commitNull;
    logic fault;
  } ctrlStrobe_t;

  localparam segCache_t CACHE_RESET = '{sel: '0, base: '0, limit: '1,
                                        dpl: '0, attr: '0, valid: 1'b1};
endpackage

// File: rtl/segLoadCtrl.sv
module segLoadCtrl
  import segLoadPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        tgtIsCode,
  input  logic        tgtIsStack,
  input  logic        selIsNull,
  input  logic        privFail,
  output ctrlStrobe_t strobe,
  output logic        memReqValid,
  output logic        busy
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_RD_LO, ST_WT_LO, ST_RD_HI, ST_WT_HI, ST_CHECK
  } state_t;

  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strobe      = '0;
    memReqValid = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobe.latchReq = 1'b1;
        nextState       = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (tgtIsCode || (selIsNull && tgtIsStack)) begin
          strobe.fault = 1'b1;
          nextState    = ST_IDLE;
        end else if (selIsNull) begin
          strobe.commitNull = 1'b1;
          nextState         = ST_IDLE;
        end else begin
          nextState = ST_RD_LO;
        end
      end
      ST_RD_LO: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = ST_WT_LO;
      end
      ST_WT_LO: if (memRspValid) begin
        strobe.latchLo = 1'b1;
        nextState      = ST_RD_HI;
      end
      ST_RD_HI: begin
        memReqValid   = 1'b1;
        strobe.addrHi = 1'b1;
        if (memReqReady) nextState = ST_WT_HI;
      end
      ST_WT_HI: if (memRspValid) begin
        strobe.latchHi = 1'b1;
        nextState      = ST_CHECK;
      end
      ST_CHECK: begin
        if (privFail) strobe.fault  = 1'b1;
        else          strobe.commit = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R2: a read request that is not yet accepted stays raised
  assert_read_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);

  // R11: no read leaves the block while it reports idle
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid);
endmodule

// File: rtl/segLoadPath.sv
module segLoadPath
  import segLoadPkg::*;
#(
  parameter int NUM_SEGS = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [SEG_IDX_W-1:0] reqSeg,
  input  logic [SEL_W-1:0]     reqSel,
  input  logic [ADDR_W-1:0]    gdtBase,
  input  logic [ADDR_W-1:0]    ldtBase,
  input  logic [31:0]          memRspData,
  input  logic                 csFarValid,
  input  logic [SEL_W-1:0]     csFarSel,
  input  logic [SEG_IDX_W-1:0] qrySeg,
  output logic [ADDR_W-1:0]    memReqAddr,
  output logic                 tgtIsCode,
  output logic                 tgtIsStack,
  output logic                 selIsNull,
  output logic                 privFail,
  output segCache_t            qryEntry,
  output logic                 faultPulse,
  output logic [SEL_W-1:0]     faultSel
);
  localparam int IDX_W    = SEL_W - 3;
  localparam int DESC_SH  = 3;
  localparam int LIM_W    = 20;
  localparam int GRAN_SH  = 12;

  logic [SEL_W-1:0]     pendSel;
  logic [SEG_IDX_W-1:0] pendSeg;
  logic [31:0]          wordLo, wordHi;
  segCache_t            cache [NUM_SEGS];
  segCache_t            newEntry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSel <= '0;
      pendSeg <= '0;
      wordLo  <= '0;
      wordHi  <= '0;
    end else begin
      if (strobe.latchReq) begin
        pendSel <= reqSel;
        pendSeg <= reqSeg;
      end
      if (strobe.latchLo) wordLo <= memRspData;
      if (strobe.latchHi) wordHi <= memRspData;
    end
  end

  // selector fields
  logic [1:0]       rpl;
  logic             tableSel;
  logic [IDX_W-1:0] descIdx;
  assign rpl      = pendSel[1:0];
  assign tableSel = pendSel[2];
  assign descIdx  = pendSel[SEL_W-1:3];

  assign tgtIsCode  = (pendSeg == SEG_CODE);
  assign tgtIsStack = (pendSeg == SEG_STACK);
  assign selIsNull  = (pendSel[SEL_W-1:2] == '0);

  // descriptor address
  logic [ADDR_W-1:0] tableBase, descOffset;
  assign tableBase  = tableSel ? ldtBase : gdtBase;
  assign descOffset = ADDR_W'({descIdx, {DESC_SH{1'b0}}});
  assign memReqAddr = tableBase + descOffset + (strobe.addrHi ? ADDR_W'(4) : '0);

  // privilege test against the current level held in the code entry
  logic [1:0] cpl, effLevel;
  assign cpl      = cache[0].sel[1:0];
  assign effLevel = (cpl > rpl) ? cpl : rpl;
  assign privFail = effLevel > wordHi[14:13];

  // descriptor decode
  logic [LIM_W-1:0] rawLimit;
  assign rawLimit = {wordHi[19:16], wordLo[15:0]};
  always_comb begin
    newEntry.sel   = pendSel;
    newEntry.base  = {wordHi[31:24], wordHi[7:0], wordLo[31:16]};
    newEntry.limit = wordHi[23] ? {rawLimit, {GRAN_SH{1'b1}}} : ADDR_W'(rawLimit);
    newEntry.dpl   = wordHi[14:13];
    newEntry.attr  = {wordHi[23:20], wordHi[15:8]};
    newEntry.valid = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEGS; i++) cache[i] <= CACHE_RESET;
    end else begin
      for (int i = 0; i < NUM_SEGS; i++) begin
        if (strobe.commit && pendSeg == SEG_IDX_W'(i)) begin
          cache[i] <= newEntry;
        end else if (strobe.commitNull && pendSeg == SEG_IDX_W'(i)) begin
          cache[i].sel   <= pendSel;
          cache[i].valid <= 1'b0;
        end else if (i == 0 && csFarValid) begin
          cache[i].sel <= csFarSel;
        end
      end
    end
  end

  // query port: one lane per entry, selected by index
  segCache_t lane [NUM_SEGS];
  for (genvar g = 0; g < NUM_SEGS; g++) begin : gLane
    assign lane[g] = (qrySeg == SEG_IDX_W'(g)) ? cache[g] : '0;
  end
  always_comb begin
    qryEntry = '0;
    for (int i = 0; i < NUM_SEGS; i++) qryEntry = qryEntry | lane[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultPulse <= 1'b0;
      faultSel   <= '0;
    end else begin
      faultPulse <= strobe.fault;
      if (strobe.fault) faultSel <= pendSel;
    end
  end

  // R7: the request path never writes the code entry
  assert_commit_not_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit || strobe.commitNull) |-> (pendSeg != SEG_CODE));

  // R5: a load either faults or commits, never both
  assert_fault_xor_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.fault && (strobe.commit || strobe.commitNull)));

  // R10: the fault indication lasts one cycle
  assert_fault_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |=> !faultPulse);
endmodule

// File: rtl/segLoadUnit.sv
module segLoadUnit
  import segLoadPkg::*;
#(
  parameter int NUM_SEGS = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  reqSeg,
  input  logic [15:0] reqSel,
  output logic        busy,
  input  logic [31:0] gdtBase,
  input  logic [31:0] ldtBase,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic [31:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  input  logic        csFarValid,
  input  logic [15:0] csFarSel,
  input  logic [2:0]  qrySeg,
  output logic [15:0] qrySel,
  output logic [31:0] qryBase,
  output logic [31:0] qryLimit,
  output logic [1:0]  qryDpl,
  output logic [11:0] qryAttr,
  output logic        qryValid,
  output logic        faultPulse,
  output logic [15:0] faultSel
);
  ctrlStrobe_t strobe;
  segCache_t   qryEntry;
  logic        tgtIsCode, tgtIsStack, selIsNull, privFail;

  segLoadCtrl uCtrl (
    .clk, .rstN, .reqValid, .memReqReady, .memRspValid,
    .tgtIsCode, .tgtIsStack, .selIsNull, .privFail,
    .strobe, .memReqValid, .busy
  );

  segLoadPath #(.NUM_SEGS(NUM_SEGS)) uPath (
    .clk, .rstN, .strobe, .reqSeg, .reqSel, .gdtBase, .ldtBase, .memRspData,
    .csFarValid, .csFarSel, .qrySeg, .memReqAddr, .tgtIsCode, .tgtIsStack,
    .selIsNull, .privFail, .qryEntry, .faultPulse, .faultSel
  );

  assign qrySel   = qryEntry.sel;
  assign qryBase  = qryEntry.base;
  assign qryLimit = qryEntry.limit;
  assign qryDpl   = qryEntry.dpl;
  assign qryAttr  = qryEntry.attr;
  assign qryValid = qryEntry.valid;
endmodule

// File: tb/sim_segLoadUnit.sv
module sim_segLoadUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqSeg = '0;
  logic [15:0] reqSel = '0;
  logic        busy;
  logic [31:0] gdtBase = 32'h0010_0000;
  logic [31:0] ldtBase = 32'h2000_0000;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        csFarValid = 1'b0;
  logic [15:0] csFarSel = '0;
  logic [2:0]  qrySeg = '0;
  logic [15:0] qrySel;
  logic [31:0] qryBase, qryLimit;
  logic [1:0]  qryDpl;
  logic [11:0] qryAttr;
  logic        qryValid;
  logic        faultPulse;
  logic [15:0] faultSel;

  always #2 clk = ~clk;

  segLoadUnit u0 (.*);

  // descriptor memory model: one-cycle response
  logic [31:0] loWord = '0, hiWord = '0;
  logic [31:0] loAddrSeen = '0, hiAddrSeen = '0;
  int          readCount = 0;
  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (memReqValid && memReqReady) begin
      memRspValid <= 1'b1;
      memRspData  <= memReqAddr[2] ? hiWord : loWord;
      readCount   <= readCount + 1;
      if (memReqAddr[2]) hiAddrSeen <= memReqAddr;
      else               loAddrSeen <= memReqAddr;
    end
  end

  int nChecks = 0, nFail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  function automatic logic [11:0] attrOf(input logic g, input logic [1:0] dpl, input logic [3:0] typ);
    return {g, 3'b100, 1'b1, dpl, 1'b1, typ};
  endfunction

  task automatic setDesc(input logic [31:0] base, input logic [19:0] lim,
                         input logic [1:0] dpl, input logic [3:0] typ, input logic g);
    loWord = {base[15:0], lim[15:0]};
    hiWord = {base[31:24], g, 3'b100, lim[19:16], 1'b1, dpl, 1'b1, typ, base[23:16]};
  endtask

  task automatic doLoad(input logic [2:0] seg, input logic [15:0] sel,
                        output logic sawFault, output logic [15:0] fSel);
    @(negedge clk);
    reqValid = 1'b1; reqSeg = seg; reqSel = sel;
    @(negedge clk);
    reqValid = 1'b0;
    while (busy) @(negedge clk);
    sawFault = faultPulse;
    fSel     = faultSel;
  endtask

  task automatic look(input logic [2:0] seg);
    qrySeg = seg;
    #1;
  endtask

  task automatic setCs(input logic [15:0] sel);
    @(negedge clk);
    csFarValid = 1'b1; csFarSel = sel;
    @(negedge clk);
    csFarValid = 1'b0;
  endtask

  task automatic tReset();
    @(negedge clk);
    chk("R1 busy", busy, 0);
    for (int s = 0; s < 6; s++) begin
      look(3'(s));
      chk("R1 sel", qrySel, 0);
      chk("R1 base", qryBase, 0);
      chk("R1 limit", qryLimit, 32'hFFFF_FFFF);
      chk("R1 dpl", qryDpl, 0);
      chk("R1 valid", qryValid, 1);
    end
  endtask

  task automatic tGlobalLoad();
    logic f; logic [15:0] fs; int r0;
    setDesc(32'h1234_5678, 20'hABCDE, 2'd0, 4'h3, 1'b0);
    r0 = readCount;
    doLoad(3'd1, 16'h0028, f, fs);
    chk("R5 no fault", f, 0);
    chk("R2 reads", readCount - r0, 2);
    chk("R2 gdt lo addr", loAddrSeen, 32'h0010_0028);
    chk("R2 gdt hi addr", hiAddrSeen, 32'h0010_002C);
    look(3'd1);
    chk("R12 sel", qrySel, 16'h0028);
    chk("R3 base", qryBase, 32'h1234_5678);
    chk("R4 byte limit", qryLimit, 32'h000A_BCDE);
    chk("R3 dpl", qryDpl, 0);
    chk("R3 attr", qryAttr, attrOf(1'b0, 2'd0, 4'h3));
    chk("R12 valid", qryValid, 1);
    look(3'd3);
    chk("R12 other untouched", qrySel, 0);
    chk("R12 other base", qryBase, 0);
  endtask

  task automatic tLocalLoad();
    logic f; logic [15:0] fs;
    setDesc(32'hCAFE_0000, 20'h00010, 2'd0, 4'hB, 1'b1);
    doLoad(3'd3, 16'hFFFC, f, fs);
    chk("R5 no fault ldt", f, 0);
    chk("R2 ldt lo addr", loAddrSeen, 32'h2000_FFF8);
    chk("R2 ldt hi addr", hiAddrSeen, 32'h2000_FFFC);
    look(3'd3);
    chk("R4 page limit", qryLimit, 32'h0001_0FFF);
    chk("R3 base ldt", qryBase, 32'hCAFE_0000);
    chk("R3 attr ldt", qryAttr, attrOf(1'b1, 2'd0, 4'hB));
  endtask

  task automatic tRplFault();
    logic f; logic [15:0] fs;
    setDesc(32'h0000_4000, 20'h00FFF, 2'd3, 4'h2, 1'b0);
    doLoad(3'd4, 16'h0033, f, fs);
    chk("R5 dpl3 rpl3 pass", f, 0);
    setDesc(32'h0000_8000, 20'h00FFF, 2'd0, 4'h2, 1'b0);
    doLoad(3'd4, 16'h003B, f, fs);
    chk("R5 rpl3 dpl0 fault", f, 1);
    chk("R10 fault sel", fs, 16'h003B);
    @(negedge clk);
    chk("R10 pulse one cycle", faultPulse, 0);
    look(3'd4);
    chk("R5 kept sel", qrySel, 16'h0033);
    chk("R5 kept base", qryBase, 32'h0000_4000);
    chk("R5 kept dpl", qryDpl, 3);
  endtask

  task automatic tCplFault();
    logic f; logic [15:0] fs;
    setCs(16'h0003);
    look(3'd0);
    chk("R6 code sel far", qrySel, 16'h0003);
    chk("R6 code base kept", qryBase, 0);
    setDesc(32'h0000_1000, 20'h00100, 2'd0, 4'h2, 1'b0);
    doLoad(3'd5, 16'h0040, f, fs);
    chk("R6 cpl3 dpl0 fault", f, 1);
    setDesc(32'h0000_2000, 20'h00100, 2'd3, 4'h2, 1'b0);
    doLoad(3'd5, 16'h0040, f, fs);
    chk("R6 cpl3 dpl3 pass", f, 0);
    setCs(16'h0002);
    setDesc(32'h0000_3000, 20'h00100, 2'd2, 4'h2, 1'b0);
    doLoad(3'd5, 16'h0049, f, fs);
    chk("R5 max equals dpl pass", f, 0);
    setCs(16'h0001);
    setDesc(32'h0000_3000, 20'h00100, 2'd1, 4'h2, 1'b0);
    doLoad(3'd5, 16'h004A, f, fs);
    chk("R5 rpl above dpl fault", f, 1);
    setCs(16'h0000);
  endtask

  task automatic tCodeRefused();
    logic f; logic [15:0] fs; int r0;
    r0 = readCount;
    doLoad(3'd0, 16'h0028, f, fs);
    chk("R7 code fault", f, 1);
    chk("R7 fault sel", fs, 16'h0028);
    chk("R7 no reads", readCount - r0, 0);
    look(3'd0);
    chk("R7 code unchanged", qrySel, 0);
  endtask

  task automatic tNull();
    logic f; logic [15:0] fs; int r0;
    r0 = readCount;
    doLoad(3'd1, 16'h0003, f, fs);
    chk("R8 null no fault", f, 0);
    chk("R8 null no reads", readCount - r0, 0);
    look(3'd1);
    chk("R8 null sel", qrySel, 16'h0003);
    chk("R8 null invalid", qryValid, 0);
    chk("R8 null base kept", qryBase, 32'h1234_5678);
    r0 = readCount;
    doLoad(3'd2, 16'h0000, f, fs);
    chk("R9 null stack fault", f, 1);
    chk("R9 no reads", readCount - r0, 0);
    look(3'd2);
    chk("R9 stack valid kept", qryValid, 1);
  endtask

  task automatic tBusy();
    logic f; int r0;
    setDesc(32'h0000_5000, 20'h00200, 2'd0, 4'h2, 1'b0);
    r0 = readCount;
    @(negedge clk);
    reqValid = 1'b1; reqSeg = 3'd5; reqSel = 16'h0058;
    @(negedge clk);
    reqSeg = 3'd4; reqSel = 16'h0060;
    chk("R11 busy during load", busy, 1);
    @(negedge clk);
    reqValid = 1'b0;
    while (busy) @(negedge clk);
    f = faultPulse;
    chk("R11 first load ok", f, 0);
    @(negedge clk);
    chk("R11 still idle", busy, 0);
    chk("R11 only two reads", readCount - r0, 2);
    look(3'd4);
    chk("R11 ignored target kept", qrySel, 16'h0033);
    look(3'd5);
    chk("R11 accepted target", qrySel, 16'h0058);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tGlobalLoad();
    tLocalLoad();
    tRplFault();
    tCplFault();
    tCodeRefused();
    tNull();
    tBusy();
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule